// File: doc/BRIEF.md
# Bit Manipulation Unit

A 32-bit bit-manipulation datapath that applies one of seven operations to a single operand, chosen by a 3-bit opcode. The operations are: rotate right by a 5-bit amount, count leading zeros, count leading sign bits, reverse all four bytes, swap the bytes inside each 16-bit half, swap the two low bytes and sign-extend the result, and mirror all 32 bits.

The operation logic is purely combinational. A parameter adds an optional output register. With the register in place, which is the default, a result appears on `res_o` on the clock edge after its inputs are presented. A new operation can be issued on every cycle. The active-low asynchronous reset clears the output register.

Top module: `bmu_top`

## Requirements
- R1: Opcode 0 rotates `opnd_i` right by `amt_i`. Bit i of the result is operand bit (i + amt_i) mod 32, and an amount of 0 returns the operand unchanged.
- R2: Opcode 1 returns the number of consecutive zero bits counted from bit 31 downward, zero-extended to 32 bits. An all-zero operand gives 32.
- R3: Opcode 2 returns how many bits directly below bit 31 equal bit 31. Both 0x00000000 and 0xFFFFFFFF give 31.
- R4: Opcode 3 reverses the byte order: byte k of the result is operand byte 3-k.
- R5: Opcode 4 swaps the two bytes within each 16-bit half independently, so 0x12345678 gives 0x34127856.
- R6: Opcode 5 places operand bits 7:0 in result bits 15:8 and operand bits 15:8 in result bits 7:0. It then copies result bit 15 into bits 31:16.
- R7: Opcode 6 reverses the bit order: result bit i is operand bit 31-i.
- R8: Opcode 7 is unused and gives a zero result.
- R9: With the default registered output, `res_o` shows the result of the inputs sampled at the previous rising edge. While `rst_ni` is low, `res_o` is 0.
- R10: For every opcode other than 0, the value of `amt_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation select (0..7, see R1-R8 encodings) |
| opnd_i | input | 32 | Operand |
| amt_i | input | 5 | Rotate amount |
| res_o | output | 32 | Result |

## Verification
Two things can land in the same cycle: the result of one operation leaving the output register, and a different operation with a different amount being set up at the inputs. The bench changes the opcode, operand and amount on every cycle, with no idle gaps. It checks each output against the value modelled for the inputs of the previous cycle. A fault that leaks the current inputs into the output, or lets a stale rotate amount disturb a counting or reversal opcode, shows up as a mismatch.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [2:0] {
    OP_ROR   = 3'd0,
    OP_CLZ   = 3'd1,
    OP_CLS   = 3'd2,
    OP_REV   = 3'd3,
    OP_REV16 = 3'd4,
    OP_REVSH = 3'd5,
    OP_RBIT  = 3'd6,
    OP_NONE  = 3'd7
  } bmu_op_e;
endpackage

// File: rtl/bmu_rotr.sv
module bmu_rotr #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    din_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [W-1:0]    dout_o
);
  logic [W-1:0] stage [SH_W+1];
  assign stage[0] = din_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 2 ** k;
    assign stage[k+1] = sh_i[k] ? {stage[k][S-1:0], stage[k][W-1:S]} : stage[k];
  end

  assign dout_o = stage[SH_W];
endmodule

// File: rtl/bmu_lzc.sv
module bmu_lzc #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  // highest set bit wins: later iterations overwrite
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bmu_perm.sv
module bmu_perm #(
  parameter int W = 32
) (
  input  logic [W-1:0] din_i,
  output logic [W-1:0] rev_o,
  output logic [W-1:0] rev16_o,
  output logic [W-1:0] revsh_o,
  output logic [W-1:0] rbit_o
);
  localparam int NB = W / 8;

  logic [15:0] low_sw;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign rev_o[8*b +: 8]   = din_i[8*(NB-1-b) +: 8];
    assign rev16_o[8*b +: 8] = din_i[8*(b ^ 1) +: 8];
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rbit_o[i] = din_i[W-1-i];
  end

  assign low_sw  = {din_i[7:0], din_i[15:8]};
  assign revsh_o = {{(W-16){low_sw[15]}}, low_sw};
endmodule

// File: rtl/bmu_top.sv
module bmu_top
  import bmu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SH_W    = $clog2(DATA_W),
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int SGN_W = DATA_W - 1;
  localparam int SCW   = $clog2(SGN_W + 1);

  logic [DATA_W-1:0] rot_res, rev_res, rev16_res, revsh_res, rbit_res;
  logic [CNT_W-1:0]  clz_cnt;
  logic [SCW-1:0]    cls_cnt;
  logic [SGN_W-1:0]  sgn_diff;
  logic [DATA_W-1:0] res_d;

  bmu_rotr #(.W(DATA_W), .SH_W(SH_W)) rot_i (
    .din_i (opnd_i),
    .sh_i  (amt_i),
    .dout_o(rot_res)
  );

  bmu_lzc #(.W(DATA_W), .CNT_W(CNT_W)) clz_i (
    .vec_i(opnd_i),
    .cnt_o(clz_cnt)
  );

  // bits that differ from the sign bit, sign bit itself excluded
  assign sgn_diff = opnd_i[SGN_W-1:0] ^ {SGN_W{opnd_i[DATA_W-1]}};

  bmu_lzc #(.W(SGN_W), .CNT_W(SCW)) cls_i (
    .vec_i(sgn_diff),
    .cnt_o(cls_cnt)
  );

  bmu_perm #(.W(DATA_W)) perm_i (
    .din_i  (opnd_i),
    .rev_o  (rev_res),
    .rev16_o(rev16_res),
    .revsh_o(revsh_res),
    .rbit_o (rbit_res)
  );

  always_comb begin
    unique case (bmu_op_e'(op_i))
      OP_ROR:   res_d = rot_res;
      OP_CLZ:   res_d = DATA_W'(clz_cnt);
      OP_CLS:   res_d = DATA_W'(cls_cnt);
      OP_REV:   res_d = rev_res;
      OP_REV16: res_d = rev16_res;
      OP_REVSH: res_d = revsh_res;
      OP_RBIT:  res_d = rbit_res;
      default:  res_d = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_o <= '0;
      else         res_o <= res_d;
    end
  end else begin : g_comb
    assign res_o = res_d;
  end
endmodule

// File: rtl/bmu_chk.sv
module bmu_chk
  import bmu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SH_W    = $clog2(DATA_W),
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [SH_W-1:0]   amt_i,
  input logic [DATA_W-1:0] res_o
);
  if (REG_OUT) begin : g_chk
    // R9
    always @(posedge clk_i) begin
      if (rst_ni === 1'b0) begin
        rst_zero_chk: assert (res_o == '0);
      end
    end

    // R1
    rot_zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_ROR && amt_i == '0) |=> res_o == $past(opnd_i));

    // R1
    rot_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_ROR) |=> $countones(res_o) == $countones($past(opnd_i)));

    // R2
    clz_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_CLZ && opnd_i == '0) |=> res_o == DATA_W);

    // R2
    clz_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_CLZ) |=> res_o <= DATA_W);

    // R3
    cls_flat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_CLS && (opnd_i == '0 || opnd_i == '1)) |=> res_o == DATA_W - 1);

    // R4
    rev_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_REV) |=> $countones(res_o) == $countones($past(opnd_i)));

    // R6
    revsh_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_REVSH) |=> ($countones(res_o[DATA_W-1:15]) == 0 ||
                              $countones(res_o[DATA_W-1:15]) == DATA_W - 15));

    // R7
    rbit_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_RBIT) |=> $countones(res_o) == $countones($past(opnd_i)));

    // R8
    unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_NONE) |=> res_o == '0);
  end
endmodule

bind bmu_top bmu_chk #(.DATA_W(DATA_W), .SH_W(SH_W), .REG_OUT(REG_OUT)) chk_i (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .op_i  (op_i),
  .opnd_i(opnd_i),
  .amt_i (amt_i),
  .res_o (res_o)
);

// File: tb/bmu_top_tb_top.sv
module bmu_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] opnd_i = 32'hA5A5_0F0F;
  logic [4:0]  amt_i = 5'd3;
  logic [31:0] res_o;

  int n_chk = 0;
  int n_err = 0;

  logic        pend = 1'b0;
  logic [31:0] pend_exp;
  string       pend_tag;

  always #(CLK_P/2) clk_i = ~clk_i;

  bmu_top dut_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op_i),
    .opnd_i(opnd_i),
    .amt_i (amt_i),
    .res_o (res_o)
  );

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] x,
                                        input logic [4:0] a);
    logic [31:0] r;
    int n;
    r = '0;
    case (op)
      3'd0: for (int i = 0; i < 32; i++) r[i] = x[(i + a) % 32];
      3'd1: begin
        n = 0;
        for (int j = 31; j >= 0 && x[j] == 1'b0; j--) n++;
        r = n;
      end
      3'd2: begin
        n = 0;
        for (int j = 30; j >= 0 && x[j] == x[31]; j--) n++;
        r = n;
      end
      3'd3: r = {x[7:0], x[15:8], x[23:16], x[31:24]};
      3'd4: r = {x[23:16], x[31:24], x[7:0], x[15:8]};
      3'd5: r = {{16{x[7]}}, x[7:0], x[15:8]};
      3'd6: for (int i = 0; i < 32; i++) r[i] = x[31 - i];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_pend();
    if (pend) begin
      n_chk++;
      if (res_o !== pend_exp) begin
        n_err++;
        $display("FAIL %s/R9: res_o=%h expected=%h", pend_tag, res_o, pend_exp);
      end
    end
  endtask

  // back-to-back issue: check previous result, then drive next inputs
  task automatic step(input logic [2:0] op, input logic [31:0] x, input logic [4:0] a,
                      input string tag);
    @(negedge clk_i);
    check_pend();
    op_i     = op;
    opnd_i   = x;
    amt_i    = a;
    pend     = 1'b1;
    pend_exp = model(op, x, a);
    pend_tag = tag;
  endtask

  task automatic flush();
    @(negedge clk_i);
    check_pend();
    pend = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] x;
    logic [2:0]  op;
    void'($urandom(32'h0000_BEEF));

    // R9: reset holds output at zero despite live inputs
    repeat (2) @(negedge clk_i);
    n_chk++;
    if (res_o !== 32'h0) begin
      n_err++;
      $display("FAIL R9: reset res_o=%h expected=%h", res_o, 32'h0);
    end
    rst_ni = 1'b1;

    // R1 rotate corners
    step(3'd0, 32'h8000_0001, 5'd1,  "R1");
    step(3'd0, 32'hDEAD_BEEF, 5'd0,  "R1");
    step(3'd0, 32'h8000_0001, 5'd31, "R1");
    // R2 leading zeros
    step(3'd1, 32'h0000_0000, 5'd7,  "R2");
    step(3'd1, 32'h0000_0001, 5'd0,  "R2");
    step(3'd1, 32'h8000_0000, 5'd0,  "R2");
    // R3 leading sign bits
    step(3'd2, 32'h0000_0000, 5'd0,  "R3");
    step(3'd2, 32'hFFFF_FFFF, 5'd0,  "R3");
    step(3'd2, 32'h4000_0000, 5'd0,  "R3");
    step(3'd2, 32'hC000_0000, 5'd0,  "R3");
    step(3'd2, 32'hFFFF_FFFE, 5'd0,  "R3");
    // R4..R7 permutations
    step(3'd3, 32'h1234_5678, 5'd0,  "R4");
    step(3'd4, 32'h1234_5678, 5'd0,  "R5");
    step(3'd5, 32'h0000_0080, 5'd0,  "R6");
    step(3'd5, 32'h1234_FF7F, 5'd0,  "R6");
    step(3'd5, 32'h0000_0000, 5'd0,  "R6");
    step(3'd6, 32'h0000_0001, 5'd0,  "R7");
    step(3'd6, 32'h1234_5678, 5'd0,  "R7");
    // R8 unused opcode
    step(3'd7, 32'hFFFF_FFFF, 5'd9,  "R8");
    // R10: amount must not matter outside rotate
    for (int o = 1; o < 8; o++) begin
      step(3'(o), 32'h00F0_8013, 5'd0,  "R10");
      step(3'(o), 32'h00F0_8013, 5'd17, "R10");
      step(3'(o), 32'h00F0_8013, 5'd31, "R10");
    end

    // random stream, opcode changes every cycle
    for (int n = 0; n < 4000; n++) begin
      case ($urandom % 6)
        0: x = 32'h0;
        1: x = 32'hFFFF_FFFF;
        2: x = 32'h1 << ($urandom % 32);
        3: x = ~(32'h1 << ($urandom % 32));
        4: x = $urandom >> ($urandom % 32);
        default: x = $urandom;
      endcase
      op = 3'($urandom % 8);
      step(op, x, 5'($urandom), tag_of(op));
    end
    flush();

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule